// File: doc/BRIEF.md
# Core Regulator Fault Supervisor

This block supervises a multiphase core regulator from the digital side. Each clock it sees a digitized sample of the core voltage, the programmed reference code, an overcurrent flag from the current-sense path and a supply power-on-reset level. It decides whether the PWM outputs switch normally, are all pulled low to crowbar the rail, or are all left floating. It drives the power-good output and sequences soft-start as a wait phase followed by a ramp phase. Phase lengths are counted in PWM cycles, each marked by a one-clock tick.

Three faults are handled differently. An overvoltage latches the block into a shunt mode. In that mode the outputs pull low while the rail is high and float once it has fallen back through a hysteresis band. Only a supply power-on-reset leaves this mode. An undervoltage only withdraws power-good, with hysteresis, and never latches. An overcurrent floats the outputs and starts a hiccup restart. The restart uses a much longer wait than a normal power-up before the ramp runs again.

Top module: `vr_fault_supervisor`

## Requirements
- R1: While `supplyPor` is high, `pwmMode` is 0 (floating), `pgood`, `ssWait` and `ssRamp` are low. The `pwmMode` encoding is 0 floating, 1 normal switching, 2 forced low.
- R2: After `supplyPor` falls, the block sits in the wait phase (`ssWait`=1, `pwmMode`=0) for exactly SOFT_WAIT PWM ticks.
- R3: The ramp phase (`ssRamp`=1, `pwmMode`=1) lasts exactly RAMP_LEN ticks. Regulation follows, with `pwmMode`=1 and `pgood`=1 when no fault is present.
- R4: The wait and ramp counters advance only on clocks where `pwmTick` is high. A pause in ticks stretches the phase in clocks and leaves it unchanged in ticks.
- R5: During regulation, a sample strictly below ref − ref·UV_PCT/100 drops `pgood` while `pwmMode` stays 1. A sample equal to that level does not.
- R6: Once `pgood` has dropped for undervoltage, it returns only when the sample rises strictly above the trip level plus the hysteresis band (ref·HYST_PCT/100). No latch is kept.
- R7: An overcurrent during regulation sets `pwmMode`=0 and drops `pgood`. It then runs a wait phase of HICCUP_WAIT ticks and a full ramp.
- R8: An overcurrent during the ramp restarts the long wait from zero. An overcurrent during a wait phase has no effect on its length.
- R9: A sample strictly above ref + ref·OV_PCT/100 during wait, ramp or regulation latches the overvoltage mode with `pwmMode`=2 and `pgood`=0. A sample equal to that limit does not.
- R10: In the overvoltage mode, `pwmMode` is 2 while the sample is above the limit. It becomes 0 only when the sample falls strictly below the limit minus the band, and returns to 2 only on a new crossing above the limit.
- R11: The overvoltage mode never returns to normal switching, never raises `pgood`, and ignores overcurrent. Only `supplyPor` clears it.
- R12: When overvoltage and overcurrent are seen in the same cycle, the overvoltage mode is entered and no hiccup wait starts.
- R13: A power-up after `supplyPor` uses the SOFT_WAIT wait even when the previous start was a hiccup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pwmTick | input | 1 | One-clock pulse per PWM cycle |
| supplyPor | input | 1 | Supply power-on-reset level, high holds the block off |
| senseCode | input | CODE_W | Digitized core-voltage sample |
| refCode | input | CODE_W | Programmed reference code |
| ocFlag | input | 1 | Overcurrent indication |
| pwmMode | output | 2 | 0 floating, 1 normal, 2 forced low |
| pgood | output | 1 | Power-good |
| ssWait | output | 1 | Soft-start wait phase active |
| ssRamp | output | 1 | Soft-start ramp phase active |

## Verification
The bench builds the block with SOFT_WAIT=4, HICCUP_WAIT=16 and RAMP_LEN=12, keeping the default code width and percentages with a reference of 400. The short phases let a single run cover a normal start, a hiccup with an overcurrent in the wait and another in the ramp, the full overvoltage shunt cycle and a second power-up. A reference of 400 puts the trip and release levels on whole codes (460/452 and 360/368). That allows exact probes one code on each side of every threshold.

// File: rtl/vrfs_pkg.sv
`timescale 1ns/1ps
package vrfs_pkg;

  typedef enum logic [1:0] {
    PWM_FLOAT = 2'd0,
    PWM_DRIVE = 2'd1,
    PWM_LOW   = 2'd2
  } pwmMode_e;

  typedef enum logic [2:0] {
    SV_OFF,
    SV_WAIT,
    SV_RAMP,
    SV_RUN,
    SV_OVLATCH
  } supState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClear;
    logic cntStep;
    logic rampSel;
    logic longSel;
  } dpCtl_t;

  // registered observations from datapath to control
  typedef struct packed {
    logic ovAbove;
    logic uvBelow;
    logic ocSeen;
    logic phaseDone;
  } dpStat_t;

endpackage

// File: rtl/vrfs_hyst_cmp.sv
`timescale 1ns/1ps
module vrfs_hyst_cmp #(
  parameter int WIDE_W    = 18,
  parameter bit TRIP_HIGH = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WIDE_W-1:0] sample,
  input  logic [WIDE_W-1:0] tripLevel,
  input  logic [WIDE_W-1:0] releaseLevel,
  output logic              flagQ
);

  logic tripHit;
  logic releaseHit;

  generate
    if (TRIP_HIGH) begin : g_upper
      assign tripHit    = sample > tripLevel;
      assign releaseHit = sample < releaseLevel;
    end else begin : g_lower
      assign tripHit    = sample < tripLevel;
      assign releaseHit = sample > releaseLevel;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= 1'b0;
    end else if (tripHit) begin
      flagQ <= 1'b1;
    end else if (releaseHit) begin
      flagQ <= 1'b0;
    end
  end

endmodule

// File: rtl/vrfs_datapath.sv
`timescale 1ns/1ps
module vrfs_datapath
  import vrfs_pkg::*;
#(
  parameter int CODE_W      = 10,
  parameter int SOFT_WAIT   = 32,
  parameter int HICCUP_WAIT = 2048,
  parameter int RAMP_LEN    = 2016,
  parameter int OV_PCT      = 15,
  parameter int UV_PCT      = 10,
  parameter int HYST_PCT    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] senseCode,
  input  logic [CODE_W-1:0] refCode,
  input  logic              ocFlag,
  input  dpCtl_t            ctl,
  output dpStat_t           stat
);

  localparam int WIDE_W  = CODE_W + 8;
  localparam int MAX_AB  = (SOFT_WAIT > HICCUP_WAIT) ? SOFT_WAIT : HICCUP_WAIT;
  localparam int MAX_LEN = (MAX_AB > RAMP_LEN) ? MAX_AB : RAMP_LEN;
  localparam int CNT_W   = (MAX_LEN > 2) ? $clog2(MAX_LEN) : 1;
  localparam logic [CNT_W-1:0] SOFT_LAST   = CNT_W'(SOFT_WAIT - 1);
  localparam logic [CNT_W-1:0] HICCUP_LAST = CNT_W'(HICCUP_WAIT - 1);
  localparam logic [CNT_W-1:0] RAMP_LAST   = CNT_W'(RAMP_LEN - 1);

  // threshold arithmetic on a widened reference
  logic [WIDE_W-1:0] refWide;
  logic [WIDE_W-1:0] senseWide;
  logic [WIDE_W-1:0] ovMargin;
  logic [WIDE_W-1:0] uvMargin;
  logic [WIDE_W-1:0] hystBand;
  logic [WIDE_W-1:0] ovTrip;
  logic [WIDE_W-1:0] ovRelease;
  logic [WIDE_W-1:0] uvTrip;
  logic [WIDE_W-1:0] uvRelease;

  assign refWide   = WIDE_W'(refCode);
  assign senseWide = WIDE_W'(senseCode);
  assign ovMargin  = (refWide * WIDE_W'(OV_PCT)) / WIDE_W'(100);
  assign uvMargin  = (refWide * WIDE_W'(UV_PCT)) / WIDE_W'(100);
  assign hystBand  = (refWide * WIDE_W'(HYST_PCT)) / WIDE_W'(100);
  assign ovTrip    = refWide + ovMargin;
  assign ovRelease = ovTrip - hystBand;
  assign uvTrip    = refWide - uvMargin;
  assign uvRelease = uvTrip + hystBand;

  logic ovFlagQ;
  logic uvFlagQ;

  vrfs_hyst_cmp #(
    .WIDE_W   (WIDE_W),
    .TRIP_HIGH(1'b1)
  ) ovCmp_i (
    .clk         (clk),
    .rstN        (rstN),
    .sample      (senseWide),
    .tripLevel   (ovTrip),
    .releaseLevel(ovRelease),
    .flagQ       (ovFlagQ)
  );

  vrfs_hyst_cmp #(
    .WIDE_W   (WIDE_W),
    .TRIP_HIGH(1'b0)
  ) uvCmp_i (
    .clk         (clk),
    .rstN        (rstN),
    .sample      (senseWide),
    .tripLevel   (uvTrip),
    .releaseLevel(uvRelease),
    .flagQ       (uvFlagQ)
  );

  // overcurrent flag takes the same one-cycle latency as the comparators
  logic ocQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ocQ <= 1'b0;
    end else begin
      ocQ <= ocFlag;
    end
  end

  // shared phase counter, counts PWM ticks
  logic [CNT_W-1:0] phaseCnt;
  logic [CNT_W-1:0] phaseLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
    end else if (ctl.cntClear) begin
      phaseCnt <= '0;
    end else if (ctl.cntStep) begin
      phaseCnt <= phaseCnt + 1'b1;
    end
  end

  always_comb begin
    if (ctl.rampSel) begin
      phaseLast = RAMP_LAST;
    end else if (ctl.longSel) begin
      phaseLast = HICCUP_LAST;
    end else begin
      phaseLast = SOFT_LAST;
    end
  end

  assign stat.ovAbove   = ovFlagQ;
  assign stat.uvBelow   = uvFlagQ;
  assign stat.ocSeen    = ocQ;
  assign stat.phaseDone = (phaseCnt == phaseLast);

endmodule

// File: rtl/vrfs_control.sv
`timescale 1ns/1ps
module vrfs_control
  import vrfs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwmTick,
  input  logic       supplyPor,
  input  dpStat_t    stat,
  output dpCtl_t     ctl,
  output logic [1:0] pwmMode,
  output logic       pgood,
  output logic       ssWait,
  output logic       ssRamp
);

  supState_e state;
  supState_e nextState;
  logic      longWait;
  logic      nextLong;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= SV_OFF;
      longWait <= 1'b0;
    end else begin
      state    <= nextState;
      longWait <= nextLong;
    end
  end

  always_comb begin
    nextState   = state;
    nextLong    = longWait;
    ctl         = '0;
    ctl.rampSel = (state == SV_RAMP);
    ctl.longSel = longWait;
    case (state)
      SV_OFF: begin
        nextState    = SV_WAIT;
        nextLong     = 1'b0;
        ctl.cntClear = 1'b1;
      end
      SV_WAIT: begin
        // overcurrent is not acted on while already waiting
        if (stat.ovAbove) begin
          nextState = SV_OVLATCH;
        end else if (pwmTick) begin
          if (stat.phaseDone) begin
            nextState    = SV_RAMP;
            ctl.cntClear = 1'b1;
          end else begin
            ctl.cntStep = 1'b1;
          end
        end
      end
      SV_RAMP: begin
        if (stat.ovAbove) begin
          nextState = SV_OVLATCH;
        end else if (stat.ocSeen) begin
          nextState    = SV_WAIT;
          nextLong     = 1'b1;
          ctl.cntClear = 1'b1;
        end else if (pwmTick) begin
          if (stat.phaseDone) begin
            nextState    = SV_RUN;
            ctl.cntClear = 1'b1;
          end else begin
            ctl.cntStep = 1'b1;
          end
        end
      end
      SV_RUN: begin
        if (stat.ovAbove) begin
          nextState = SV_OVLATCH;
        end else if (stat.ocSeen) begin
          nextState    = SV_WAIT;
          nextLong     = 1'b1;
          ctl.cntClear = 1'b1;
        end
      end
      SV_OVLATCH: begin
        nextState = SV_OVLATCH;
      end
      default: begin
        nextState = SV_OFF;
      end
    endcase
    if (supplyPor) begin
      nextState    = SV_OFF;
      nextLong     = 1'b0;
      ctl.cntClear = 1'b1;
      ctl.cntStep  = 1'b0;
    end
  end

  always_comb begin
    case (state)
      SV_RAMP, SV_RUN: pwmMode = PWM_DRIVE;
      SV_OVLATCH:      pwmMode = stat.ovAbove ? PWM_LOW : PWM_FLOAT;
      default:         pwmMode = PWM_FLOAT;
    endcase
  end

  assign pgood  = (state == SV_RUN) && !stat.uvBelow;
  assign ssWait = (state == SV_WAIT);
  assign ssRamp = (state == SV_RAMP);

endmodule

// File: rtl/vr_fault_supervisor.sv
`timescale 1ns/1ps
module vr_fault_supervisor
  import vrfs_pkg::*;
#(
  parameter int CODE_W      = 10,
  parameter int SOFT_WAIT   = 32,
  parameter int HICCUP_WAIT = 2048,
  parameter int RAMP_LEN    = 2016,
  parameter int OV_PCT      = 15,
  parameter int UV_PCT      = 10,
  parameter int HYST_PCT    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pwmTick,
  input  logic              supplyPor,
  input  logic [CODE_W-1:0] senseCode,
  input  logic [CODE_W-1:0] refCode,
  input  logic              ocFlag,
  output logic [1:0]        pwmMode,
  output logic              pgood,
  output logic              ssWait,
  output logic              ssRamp
);

  dpCtl_t  dpControl;
  dpStat_t dpStatus;
  logic    ovAboveTap;
  logic    ocSeenTap;

  vrfs_datapath #(
    .CODE_W     (CODE_W),
    .SOFT_WAIT  (SOFT_WAIT),
    .HICCUP_WAIT(HICCUP_WAIT),
    .RAMP_LEN   (RAMP_LEN),
    .OV_PCT     (OV_PCT),
    .UV_PCT     (UV_PCT),
    .HYST_PCT   (HYST_PCT)
  ) datapath_i (
    .clk      (clk),
    .rstN     (rstN),
    .senseCode(senseCode),
    .refCode  (refCode),
    .ocFlag   (ocFlag),
    .ctl      (dpControl),
    .stat     (dpStatus)
  );

  vrfs_control control_i (
    .clk      (clk),
    .rstN     (rstN),
    .pwmTick  (pwmTick),
    .supplyPor(supplyPor),
    .stat     (dpStatus),
    .ctl      (dpControl),
    .pwmMode  (pwmMode),
    .pgood    (pgood),
    .ssWait   (ssWait),
    .ssRamp   (ssRamp)
  );

  assign ovAboveTap = dpStatus.ovAbove;
  assign ocSeenTap  = dpStatus.ocSeen;

endmodule

// File: rtl/vrfs_checker.sv
`timescale 1ns/1ps
module vrfs_checker (
  input logic       clk,
  input logic       rstN,
  input logic       pwmTick,
  input logic       supplyPor,
  input logic [1:0] pwmMode,
  input logic       pgood,
  input logic       ssWait,
  input logic       ssRamp,
  input logic       ovAbove,
  input logic       ocSeen
);

  // R1
  por_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    supplyPor |=> (pwmMode == 2'd0 && !pgood && !ssWait && !ssRamp));

  // R2
  wait_float_chk: assert property (@(posedge clk) disable iff (!rstN)
    ssWait |-> (pwmMode == 2'd0 && !ssRamp && !pgood));

  // R3
  pgood_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    pgood |-> (pwmMode == 2'd1 && !ssWait && !ssRamp));

  // R4
  tick_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ssWait && !pwmTick && !supplyPor && !ovAbove) |=> ssWait);

  // R11
  ov_stays_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pwmMode == 2'd2 && !supplyPor) |=> (pwmMode != 2'd1 && !pgood && !ssWait));

  // R12
  ov_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovAbove && ocSeen && pwmMode == 2'd1 && !supplyPor) |=> (!ssWait && !pgood && pwmMode != 2'd1));

endmodule

bind vr_fault_supervisor vrfs_checker chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .pwmTick  (pwmTick),
  .supplyPor(supplyPor),
  .pwmMode  (pwmMode),
  .pgood    (pgood),
  .ssWait   (ssWait),
  .ssRamp   (ssRamp),
  .ovAbove  (ovAboveTap),
  .ocSeen   (ocSeenTap)
);

// File: tb/vr_fault_supervisor_tb.sv
`timescale 1ns/1ps
module vr_fault_supervisor_tb_top;

  localparam int CODE_W = 10;
  localparam int SOFT   = 4;
  localparam int HICCUP = 16;
  localparam int RAMP   = 12;

  logic              clk = 1'b0;
  logic              rstN;
  logic              pwmTick;
  logic              supplyPor;
  logic [CODE_W-1:0] senseCode;
  logic [CODE_W-1:0] refCode;
  logic              ocFlag;
  logic [1:0]        pwmMode;
  logic              pgood;
  logic              ssWait;
  logic              ssRamp;

  always #4 clk = ~clk;

  vr_fault_supervisor #(
    .CODE_W     (CODE_W),
    .SOFT_WAIT  (SOFT),
    .HICCUP_WAIT(HICCUP),
    .RAMP_LEN   (RAMP)
  ) dut_i (
    .clk      (clk),
    .rstN     (rstN),
    .pwmTick  (pwmTick),
    .supplyPor(supplyPor),
    .senseCode(senseCode),
    .refCode  (refCode),
    .ocFlag   (ocFlag),
    .pwmMode  (pwmMode),
    .pgood    (pgood),
    .ssWait   (ssWait),
    .ssRamp   (ssRamp)
  );

  typedef struct {
    int    mode;
    int    pg;
    int    wt;
    int    rp;
    int    prevTicks;
    string req;
  } expItem_t;

  expItem_t expQ[$];
  int  testsRun    = 0;
  int  testsFailed = 0;
  bit  monEnable   = 1'b0;
  bit  tickEnable  = 1'b1;
  bit  done        = 1'b0;

  task automatic check(string req, string what, int act, int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push(int mode, int pg, int wt, int rp, int prevTicks, string req);
    expItem_t item;
    item.mode = mode; item.pg = pg; item.wt = wt; item.rp = rp;
    item.prevTicks = prevTicks; item.req = req;
    expQ.push_back(item);
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(negedge clk);
    repeat (3) step();
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  endtask

  // PWM tick source: one pulse every third clock
  initial begin
    pwmTick = 1'b0;
    for (int div = 0; ; div = (div == 2) ? 0 : div + 1) begin
      @(posedge clk);
      #1;
      pwmTick = (div == 2) && tickEnable;
    end
  end

  // monitor: every change of the output tuple is checked against the queue
  initial begin
    int lastTuple;
    int phaseTicks;
    lastTuple  = 0;
    phaseTicks = 0;
    forever begin
      @(negedge clk);
      if (monEnable) begin
        int curTuple;
        curTuple = {27'd0, pwmMode, pgood, ssWait, ssRamp};
        if (curTuple != lastTuple) begin
          if (expQ.size() == 0) begin
            check("R0", "unexpected output change", curTuple, lastTuple);
          end else begin
            expItem_t item;
            item = expQ.pop_front();
            check(item.req, "output tuple {mode,pgood,wait,ramp}", curTuple,
                  (item.mode << 3) | (item.pg << 2) | (item.wt << 1) | item.rp);
            if (item.prevTicks >= 0)
              check(item.req, "ticks in ended phase", phaseTicks, item.prevTicks);
          end
          lastTuple  = curTuple;
          phaseTicks = 0;
        end
        if ((ssWait || ssRamp) && pwmTick) phaseTicks++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    rstN      = 1'b0;
    supplyPor = 1'b1;
    ocFlag    = 1'b0;
    senseCode = 10'd400;
    refCode   = 10'd400;
    repeat (3) step();
    @(negedge clk);
    // R1 reset state
    check("R1", "reset tuple", {pwmMode, pgood, ssWait, ssRamp}, 0);
    step();
    rstN = 1'b1;
    repeat (4) step();
    check("R1", "held by supplyPor", {pwmMode, pgood, ssWait, ssRamp}, 0);
    monEnable = 1'b1;

    // R2 R3 R4: normal start, with a tick pause inside the wait
    push(0, 0, 1, 0, -1, "R2");
    push(1, 0, 0, 1, SOFT, "R4");
    push(1, 1, 0, 0, RAMP, "R3");
    supplyPor = 1'b0;
    do @(negedge clk); while (!ssWait);
    tickEnable = 1'b0;
    repeat (20) @(negedge clk);
    check("R4", "still waiting after tick pause", ssWait, 1);
    tickEnable = 1'b1;
    drain();

    // R5: boundary then trip
    senseCode = 10'd360;
    repeat (5) step();
    check("R5", "pgood at trip level", pgood, 1);
    push(1, 0, 0, 0, -1, "R5");
    senseCode = 10'd359;
    drain();
    // R6: inside band then release
    senseCode = 10'd365;
    repeat (6) step();
    check("R6", "pgood inside band", pgood, 0);
    push(1, 1, 0, 0, -1, "R6");
    senseCode = 10'd369;
    drain();
    senseCode = 10'd400;

    // R7: overcurrent in regulation, R8: pulse during wait is ignored
    push(0, 0, 1, 0, -1, "R7");
    push(1, 0, 0, 1, HICCUP, "R8");
    ocFlag = 1'b1;
    step();
    ocFlag = 1'b0;
    repeat (12) step();
    ocFlag = 1'b1;
    step();
    ocFlag = 1'b0;
    drain();
    // R8: overcurrent during ramp restarts the long wait
    repeat (6) step();
    push(0, 0, 1, 0, -1, "R8");
    push(1, 0, 0, 1, HICCUP, "R8");
    push(1, 1, 0, 0, RAMP, "R7");
    ocFlag = 1'b1;
    step();
    ocFlag = 1'b0;
    drain();

    // R9 boundary, R12 priority
    senseCode = 10'd460;
    repeat (5) step();
    check("R9", "mode at ov limit", pwmMode, 1);
    push(2, 0, 0, 0, -1, "R12");
    senseCode = 10'd461;
    ocFlag = 1'b1;
    repeat (3) step();
    ocFlag = 1'b0;
    drain();
    check("R12", "no hiccup wait", ssWait, 0);
    // R10 hysteretic shunt
    senseCode = 10'd455;
    repeat (5) step();
    check("R10", "low inside band", pwmMode, 2);
    push(0, 0, 0, 0, -1, "R10");
    senseCode = 10'd451;
    drain();
    senseCode = 10'd458;
    repeat (5) step();
    check("R10", "float inside band", pwmMode, 0);
    push(2, 0, 0, 0, -1, "R10");
    senseCode = 10'd461;
    drain();
    push(0, 0, 0, 0, -1, "R10");
    senseCode = 10'd400;
    drain();
    // R11 latch holds, overcurrent ignored
    ocFlag = 1'b1;
    step();
    ocFlag = 1'b0;
    repeat (60) step();
    check("R11", "latched tuple", {pwmMode, pgood, ssWait, ssRamp}, 0);

    // R13: power-on-reset clears latch, short wait again
    supplyPor = 1'b1;
    repeat (3) step();
    check("R1", "off under supplyPor", {pwmMode, pgood, ssWait, ssRamp}, 0);
    push(0, 0, 1, 0, -1, "R13");
    push(1, 0, 0, 1, SOFT, "R13");
    push(1, 1, 0, 0, RAMP, "R13");
    supplyPor = 1'b0;
    drain();
    repeat (10) step();
    check("R13", "pgood after restart", pgood, 1);
    check("R0", "pending expected items", expQ.size(), 0);
    finishRun();
  end

endmodule